// File: doc/BRIEF.md
# Interrupt Source PQ Coalescing Unit

This block keeps a two-bit state for each member of a small array of interrupt sources and decides when a source may raise a notification. Bit 1 (P) records that a notification has gone out and still awaits end-of-interrupt. Bit 0 (Q) records that at least one more trigger arrived while P was set. Repeated triggers therefore collapse into at most one outstanding notification per source. On end-of-interrupt the Q bit decides whether the source fires again. The state value 01 acts as a mask.

Sources are triggered by per-source pulse inputs, or by software through a load/store bus. The bus address holds a region bit, a source index and a page offset. In the control region, loads at fixed offsets return the current state or replace it. Each such load returns the state as it was just before the access. A store at offset zero of the control region is an end-of-interrupt. A store anywhere in the trigger region is a software trigger. Accepted notifications leave on a valid/ready port that carries the source number. While the port is stalled, each waiting source keeps a request bit, so no notification is lost.

Top module: `pq_coalesce_unit`

## Requirements
- R1: A load at control offset 0x800 answers one cycle later with rsp_valid high. The source state appears in rsp_data bits [1:0] (bit 1 = P, bit 0 = Q). All other data bits are zero. The state is not changed.
- R2: Loads at control offsets 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11. Each returns the state as it was before that update. A set never raises a notification by itself.
- R3: On a trigger, state 00 becomes 10 and raises one notification. State 10 becomes 11. State 11 stays 11. Neither of the last two raises a notification.
- R4: State 01 is masked: a trigger leaves it at 01 and raises no notification.
- R5: A store at control offset 0 is end-of-interrupt. It moves 10 to 00, and moves 11 to 10 with a fresh notification. It leaves 00 and 01 unchanged.
- R6: A store with the region bit (address bit PAGE_SHIFT+IDX_W) set acts as a trigger for the indexed source.
- R7: The source index is taken from address bits [PAGE_SHIFT +: IDX_W]. A load at any other offset, or in the trigger region, returns zero and changes nothing. A store at any non-zero control offset is ignored.
- R8: When a bus operation and a trigger reach the same source in the same cycle, the bus operation is applied first, and the trigger is then evaluated on its result.
- R9: While ntf_valid is high and ntf_ready is low, ntf_valid stays high and ntf_src stays the same. A source that already has a waiting notification does not get a second one.
- R10: When several sources are waiting, the lowest source number is offered first.
- R11: After reset, every source state is 00, no notification is waiting, and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NUM_SRC | Per-source trigger pulses |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | PAGE_SHIFT+IDX_W+1 | Region bit, source index, page offset |
| rsp_valid | output | 1 | Load data valid (one cycle after the load) |
| rsp_data | output | DATA_W | Previous state in bits [1:0], zero above |
| ntf_valid | output | 1 | A notification is offered |
| ntf_ready | input | 1 | Consumer accepts the offered notification |
| ntf_src | output | IDX_W | Source number of the offered notification |

## Verification
The bench builds the unit with four sources, a 12-bit page shift and 64-bit load data. With these values every source and every control offset can be reached with short addresses, and the zero upper data bits are checked on each load. Four sources are enough for two to wait on the port at once, so the stall hold and lowest-first ordering can be observed. They also allow a stalled notification to be checked for being kept while a lower source raises a new one.

// File: rtl/pq_pkg.sv
package pq_pkg;

   // decoded bus operation
   typedef enum logic [2:0] {
      OP_NONE,
      OP_GET,
      OP_SET,
      OP_EOI,
      OP_SWTRIG,
      OP_BADLD
   } bus_op_e;

   localparam logic [1:0] PQ_IDLE   = 2'b00;
   localparam logic [1:0] PQ_MASKED = 2'b01;
   localparam logic [1:0] PQ_PEND   = 2'b10;
   localparam logic [1:0] PQ_QUEUED = 2'b11;

   localparam logic [11:0] OFS_GET = 12'h800;
   localparam logic [11:0] OFS_EOI = 12'h000;

endpackage

// File: rtl/pq_bus_decode.sv
module pq_bus_decode
   import pq_pkg::*;
#(
   parameter int NUM_SRC    = 4,
   parameter int PAGE_SHIFT = 12,
   localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int ADDR_W    = PAGE_SHIFT + IDX_W + 1
) (
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output bus_op_e           op,
   output logic [IDX_W-1:0]  idx,
   output logic [1:0]        set_val
);

   logic [PAGE_SHIFT-1:0] ofs;
   logic [11:0]           ofs_lo;
   logic                  ofs_hi_zero;
   logic                  trig_rgn;
   logic                  idx_ok;

   assign ofs         = bus_addr[PAGE_SHIFT-1:0];
   assign ofs_lo      = ofs[11:0];
   assign ofs_hi_zero = (ofs >> 12) == '0;
   assign trig_rgn    = bus_addr[ADDR_W-1];
   assign idx         = bus_addr[PAGE_SHIFT +: IDX_W];
   assign idx_ok      = 32'(idx) < NUM_SRC;
   assign set_val     = ofs_lo[9:8];

   always_comb begin
      op = OP_NONE;
      if (bus_req) begin
         if (bus_we) begin
            if (idx_ok && trig_rgn)
               op = OP_SWTRIG;
            else if (idx_ok && ofs_hi_zero && ofs_lo == OFS_EOI)
               op = OP_EOI;
         end else begin
            op = OP_BADLD;
            if (idx_ok && !trig_rgn && ofs_hi_zero) begin
               if (ofs_lo == OFS_GET)
                  op = OP_GET;
               else if (ofs_lo[11:10] == 2'b11 && ofs_lo[7:0] == 8'h00)
                  op = OP_SET;
            end
         end
      end
   end

endmodule

// File: rtl/pq_source_cell.sv
module pq_source_cell
   import pq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  bus_op_e    op,
   input  logic [1:0] set_val,
   input  logic       hw_trig,
   input  logic       grant,
   output logic [1:0] pq,
   output logic       req
);

   logic [1:0] pq_mid;
   logic [1:0] pq_nxt;
   logic       eoi_ntf;
   logic       trg_ntf;
   logic       trig;

   // bus operation first
   always_comb begin
      pq_mid  = pq;
      eoi_ntf = 1'b0;
      if (hit) begin
         unique case (op)
            OP_SET: pq_mid = set_val;
            OP_EOI: begin
               if (pq == PQ_PEND)
                  pq_mid = PQ_IDLE;
               else if (pq == PQ_QUEUED) begin
                  pq_mid  = PQ_PEND;
                  eoi_ntf = 1'b1;
               end
            end
            default: pq_mid = pq;
         endcase
      end
   end

   // trigger evaluated on the post-bus state
   assign trig = hw_trig | (hit && op == OP_SWTRIG);

   always_comb begin
      pq_nxt  = pq_mid;
      trg_ntf = 1'b0;
      if (trig) begin
         if (pq_mid == PQ_IDLE) begin
            pq_nxt  = PQ_PEND;
            trg_ntf = 1'b1;
         end else if (pq_mid == PQ_PEND)
            pq_nxt = PQ_QUEUED;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pq  <= PQ_IDLE;
         req <= 1'b0;
      end else begin
         pq  <= pq_nxt;
         req <= (req & ~grant) | eoi_ntf | trg_ntf;
      end
   end

   p_masked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pq == PQ_MASKED && !hit) |=> pq == PQ_MASKED);

   p_req_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !grant) |=> req);

   p_ntf_sets_p_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_ntf || trg_ntf) |=> (pq[1] && req));

endmodule

// File: rtl/pq_notify_arb.sv
module pq_notify_arb #(
   parameter int NUM_SRC = 4,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic               ready,
   output logic               valid,
   output logic [IDX_W-1:0]   src,
   output logic [NUM_SRC-1:0] grant
);

   logic             holding;
   logic [IDX_W-1:0] hold_idx;
   logic [IDX_W-1:0] pick;

   // lowest index wins
   always_comb begin
      pick = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--)
         if (req[i]) pick = IDX_W'(i);
   end

   assign valid = |req;
   assign src   = holding ? hold_idx : pick;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_grant
      assign grant[g] = valid && ready && (src == IDX_W'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         holding  <= 1'b0;
         hold_idx <= '0;
      end else begin
         holding  <= valid && !ready;
         hold_idx <= src;
      end
   end

   p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && src == $past(src)));

   p_grant_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

endmodule

// File: rtl/pq_coalesce_unit.sv
module pq_coalesce_unit
   import pq_pkg::*;
#(
   parameter int NUM_SRC    = 4,
   parameter int PAGE_SHIFT = 12,
   parameter int DATA_W     = 64,
   localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int ADDR_W    = PAGE_SHIFT + IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] trig_i,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_data,
   output logic               ntf_valid,
   input  logic               ntf_ready,
   output logic [IDX_W-1:0]   ntf_src
);

   if (NUM_SRC < 2) begin : g_chk_src
      $error("pq_coalesce_unit: NUM_SRC must be at least 2");
   end
   if (PAGE_SHIFT < 12) begin : g_chk_page
      $error("pq_coalesce_unit: PAGE_SHIFT must be at least 12");
   end
   if (DATA_W < 2) begin : g_chk_data
      $error("pq_coalesce_unit: DATA_W must be at least 2");
   end

   bus_op_e            op;
   logic [IDX_W-1:0]   idx;
   logic [1:0]         set_val;
   logic [1:0]         pq   [NUM_SRC];
   logic [NUM_SRC-1:0] req;
   logic [NUM_SRC-1:0] grant;
   logic [1:0]         old_pq;

   pq_bus_decode #(
      .NUM_SRC   (NUM_SRC),
      .PAGE_SHIFT(PAGE_SHIFT)
   ) u_dec (
      .bus_req (bus_req),
      .bus_we  (bus_we),
      .bus_addr(bus_addr),
      .op      (op),
      .idx     (idx),
      .set_val (set_val)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      pq_source_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .hit    (op != OP_NONE && idx == IDX_W'(g)),
         .op     (op),
         .set_val(set_val),
         .hw_trig(trig_i[g]),
         .grant  (grant[g]),
         .pq     (pq[g]),
         .req    (req[g])
      );
   end

   pq_notify_arb #(
      .NUM_SRC(NUM_SRC)
   ) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req),
      .ready(ntf_ready),
      .valid(ntf_valid),
      .src  (ntf_src),
      .grant(grant)
   );

   // state before this cycle's update
   always_comb begin
      old_pq = 2'b00;
      if (op == OP_GET || op == OP_SET)
         old_pq = pq[idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= bus_req && !bus_we;
         rsp_data  <= {{(DATA_W-2){1'b0}}, old_pq};
      end
   end

   p_load_answers_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> rsp_valid);

   p_store_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |=> !rsp_valid);

   p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_data >> 2) == '0);

endmodule

// File: tb/pq_coalesce_unit_bench.sv
`timescale 1ns/1ps
module pq_coalesce_unit_bench;

   localparam int NSRC = 4;
   localparam int PSH  = 12;
   localparam int DW   = 64;
   localparam int AW   = PSH + 2 + 1;

   localparam logic [1:0] NO = 2'd0;
   localparam logic [1:0] LD = 2'd1;
   localparam logic [1:0] ST = 2'd2;

   typedef struct packed {
      logic [1:0]  kind;
      logic        rgn;
      logic [1:0]  src;
      logic [11:0] ofs;
      logic [3:0]  trg;
      logic        rdy;
      logic [1:0]  epq;
      logic        env;
      logic [1:0]  ens;
      logic [3:0]  rq;
   } vec_t;

   // kind rgn src ofs trg rdy epq env ens rq
   localparam vec_t VECS [42] = '{
      '{LD, 1'b0, 2'd0, 12'h800, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd1},  // R1 get idle
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0010, 1'b0, 2'b00, 1'b1, 2'd1, 4'd3},  // R3 00->10
      '{LD, 1'b0, 2'd1, 12'h800, 4'b0000, 1'b0, 2'b10, 1'b1, 2'd1, 4'd1},  // R1 get 10
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0010, 1'b0, 2'b00, 1'b1, 2'd1, 4'd3},  // R3 10->11
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0001, 1'b0, 2'b00, 1'b1, 2'd1, 4'd9},  // R9 hold src1
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0000, 1'b1, 2'b00, 1'b1, 2'd0, 4'd9},  // R9 next src0
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0000, 1'b1, 2'b00, 1'b0, 2'd0, 4'd9},  // R9 drained
      '{LD, 1'b0, 2'd1, 12'h800, 4'b0000, 1'b0, 2'b11, 1'b0, 2'd0, 4'd3},  // R3 is 11
      '{ST, 1'b0, 2'd1, 12'h000, 4'b0000, 1'b0, 2'b00, 1'b1, 2'd1, 4'd5},  // R5 11->10 fire
      '{LD, 1'b0, 2'd1, 12'h800, 4'b0000, 1'b1, 2'b10, 1'b0, 2'd0, 4'd5},  // R5 is 10
      '{ST, 1'b0, 2'd1, 12'h000, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd5},  // R5 10->00
      '{LD, 1'b0, 2'd1, 12'h800, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd5},  // R5 is 00
      '{LD, 1'b0, 2'd2, 12'hD00, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd2},  // R2 set 01
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0100, 1'b0, 2'b00, 1'b0, 2'd0, 4'd4},  // R4 masked trig
      '{ST, 1'b0, 2'd2, 12'h000, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd5},  // R5 eoi on 01
      '{LD, 1'b0, 2'd2, 12'hF00, 4'b0000, 1'b0, 2'b01, 1'b0, 2'd0, 4'd4},  // R4 still 01, set 11
      '{LD, 1'b0, 2'd2, 12'h800, 4'b0000, 1'b0, 2'b11, 1'b0, 2'd0, 4'd2},  // R2 is 11
      '{LD, 1'b0, 2'd2, 12'hC00, 4'b0000, 1'b0, 2'b11, 1'b0, 2'd0, 4'd2},  // R2 set 00
      '{ST, 1'b1, 2'd3, 12'h000, 4'b0000, 1'b0, 2'b00, 1'b1, 2'd3, 4'd6},  // R6 sw trigger
      '{LD, 1'b0, 2'd3, 12'hE00, 4'b0000, 1'b1, 2'b10, 1'b0, 2'd0, 4'd2},  // R2 set 10
      '{LD, 1'b0, 2'd3, 12'h400, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd7},  // R7 bad offset
      '{ST, 1'b0, 2'd3, 12'h800, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd7},  // R7 stray store
      '{LD, 1'b0, 2'd3, 12'h800, 4'b0000, 1'b0, 2'b10, 1'b0, 2'd0, 4'd7},  // R7 unchanged
      '{LD, 1'b0, 2'd3, 12'hC00, 4'b1000, 1'b0, 2'b10, 1'b1, 2'd3, 4'd8},  // R8 set then trig
      '{LD, 1'b0, 2'd3, 12'h800, 4'b0000, 1'b1, 2'b10, 1'b0, 2'd0, 4'd8},  // R8 is 10
      '{ST, 1'b0, 2'd3, 12'h000, 4'b1000, 1'b0, 2'b00, 1'b1, 2'd3, 4'd8},  // R8 eoi then trig
      '{LD, 1'b0, 2'd3, 12'h800, 4'b0000, 1'b1, 2'b10, 1'b0, 2'd0, 4'd8},  // R8 is 10
      '{ST, 1'b0, 2'd3, 12'h000, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd5},  // R5 10->00
      '{LD, 1'b0, 2'd0, 12'h800, 4'b0000, 1'b0, 2'b10, 1'b0, 2'd0, 4'd3},  // R3 src0 is 10
      '{ST, 1'b0, 2'd0, 12'h000, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd5},  // R5 clear
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0010, 1'b0, 2'b00, 1'b1, 2'd1, 4'd3},  // R3 00->10
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0010, 1'b0, 2'b00, 1'b1, 2'd1, 4'd3},  // R3 10->11
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0010, 1'b0, 2'b00, 1'b1, 2'd1, 4'd3},  // R3 11 stays
      '{LD, 1'b0, 2'd1, 12'h800, 4'b0000, 1'b0, 2'b11, 1'b1, 2'd1, 4'd3},  // R3 is 11
      '{ST, 1'b0, 2'd1, 12'h000, 4'b0000, 1'b0, 2'b00, 1'b1, 2'd1, 4'd9},  // R9 refire merged
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0000, 1'b1, 2'b00, 1'b0, 2'd0, 4'd9},  // R9 single transfer
      '{ST, 1'b0, 2'd1, 12'h000, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd5},  // R5 10->00
      '{NO, 1'b0, 2'd0, 12'h000, 4'b1010, 1'b0, 2'b00, 1'b1, 2'd1, 4'd10}, // R10 lowest first
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0000, 1'b1, 2'b00, 1'b1, 2'd3, 4'd10}, // R10 then src3
      '{NO, 1'b0, 2'd0, 12'h000, 4'b0000, 1'b1, 2'b00, 1'b0, 2'd0, 4'd10}, // R10 drained
      '{LD, 1'b1, 2'd3, 12'h000, 4'b0000, 1'b0, 2'b00, 1'b0, 2'd0, 4'd7},  // R7 load in trigger page
      '{LD, 1'b0, 2'd3, 12'h800, 4'b0000, 1'b0, 2'b10, 1'b0, 2'd0, 4'd7}   // R7 no trigger
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] trig_i = '0;
   logic            bus_req = 1'b0;
   logic            bus_we = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic            rsp_valid;
   logic [DW-1:0]   rsp_data;
   logic            ntf_valid;
   logic            ntf_ready = 1'b0;
   logic [1:0]      ntf_src;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pq_coalesce_unit #(
      .NUM_SRC   (NSRC),
      .PAGE_SHIFT(PSH),
      .DATA_W    (DW)
   ) u_pq_coalesce_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_i   (trig_i),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .rsp_valid(rsp_valid),
      .rsp_data (rsp_data),
      .ntf_valid(ntf_valid),
      .ntf_ready(ntf_ready),
      .ntf_src  (ntf_src)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] kind, input logic rgn, input logic [1:0] src,
                        input logic [11:0] ofs, input logic [3:0] trg, input logic rdy);
      @(negedge clk);
      bus_req   = (kind != NO);
      bus_we    = (kind == ST);
      bus_addr  = {rgn, src, ofs};
      trig_i    = trg;
      ntf_ready = rdy;
      @(posedge clk);
      #1;
      bus_req   = 1'b0;
      trig_i    = '0;
   endtask

   task automatic get_pq(input logic [1:0] src, input logic [1:0] exp, input string tag);
      drive(LD, 1'b0, src, 12'h800, 4'b0000, 1'b0);
      check(tag, {63'b0, rsp_valid}, 64'd1);
      check(tag, rsp_data, {62'b0, exp});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      check("R11 ntf_valid in reset", {63'b0, ntf_valid}, 64'd0);
      check("R11 rsp_valid in reset", {63'b0, rsp_valid}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < 42; k++) begin
         vec_t v;
         string tag;
         v = VECS[k];
         tag = $sformatf("R%0d vec%0d", v.rq, k);
         drive(v.kind, v.rgn, v.src, v.ofs, v.trg, v.rdy);
         if (v.kind == LD) begin
            check({tag, " rsp_valid"}, {63'b0, rsp_valid}, 64'd1);
            check({tag, " rsp_data"}, rsp_data, {62'b0, v.epq});
         end else begin
            check({tag, " rsp_valid"}, {63'b0, rsp_valid}, 64'd0);
         end
         check({tag, " ntf_valid"}, {63'b0, ntf_valid}, {63'b0, v.env});
         if (v.env)
            check({tag, " ntf_src"}, {62'b0, ntf_src}, {62'b0, v.ens});
      end

      // R11 reset in mid-run clears states and requests
      drive(LD, 1'b0, 2'd2, 12'hF00, 4'b0000, 1'b0);
      drive(NO, 1'b0, 2'd0, 12'h000, 4'b0001, 1'b0);
      check("R11 pre-reset notify", {63'b0, ntf_valid}, 64'd1);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      check("R11 ntf_valid after reset", {63'b0, ntf_valid}, 64'd0);
      check("R11 rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      get_pq(2'd2, 2'b00, "R11 src2 cleared");
      get_pq(2'd3, 2'b00, "R11 src3 cleared");
      get_pq(2'd0, 2'b00, "R11 src0 cleared");
      check("R11 no notify after reset", {63'b0, ntf_valid}, 64'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

endmodule